// File: doc/BRIEF.md
# GPIO pad interrupt and wake detector

The block watches a set of asynchronous pad inputs, up to 48 of them, grouped into banks of 24. Each pad has a 2-bit event mode and an invert bit, supplied from pad configuration storage outside the block. The block resynchronizes every pad and detects level or edge events from consecutive samples. It records each event in two independent sticky status arrays: one for interrupts and one for wake. Software reads and clears these arrays through a simple 32-bit register port. The port also holds the matching enable words.

Pending interrupt bits that are also enabled are merged into one registered interrupt line. Pending wake bits whose pad has wake enabled, and which are not routed to the system control path, are merged into one registered wake request. Each status array clears on write-one, and a new event always beats a clear in the same cycle. A level event is therefore re-recorded for as long as the level lasts.

Top module: `gpio_pad_evt_ctrl`

## Requirements
- R1: After reset, all interrupt status, interrupt enable, wake status and wake enable bits read 0, and `irq_o` and `wake_o` are low.
- R2: Mode code 0 (level) sets a pad's status bit in every cycle that its synchronized input XOR its invert bit is 1. A clear written while that level holds leaves the bit set.
- R3: Mode code 1 (edge) sets the status bit on a rising synchronized input when the invert bit is 0, and on a falling one when it is 1. A pad change at the input reaches the status register on the third clock edge.
- R4: Mode code 2 never sets the pad's status bits.
- R5: Mode code 3 sets the status bit on both rising and falling synchronized inputs.
- R6: Interrupt status for group g is read at address 0x100+4g, with pad p at bit p%24 of group p/24. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R7: When a clear and a new event hit the same status bit in one cycle, the bit ends up set.
- R8: Interrupt enable for group g is read and written at 0x120+4g. `irq_o` is high one cycle after any bit is both pending and enabled, and low one cycle after no bit is.
- R9: Wake status sits at 0x140+4g and is set by the same events, independently of interrupt status. It is cleared by write-one. Wake enable sits at 0x160+4g. `wake_o` is the registered OR, over all pads, of wake status AND wake enable AND NOT `sci_route_i`.
- R10: Bit positions of the last group beyond the pad count never read as set in either status array. Enable words store all 24 bits. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pad_i | input | NUM_PADS | Asynchronous pad inputs |
| evcfg_i | input | 2*NUM_PADS | Event mode per pad, 2 bits at 2p |
| inv_i | input | NUM_PADS | Input invert per pad |
| sci_route_i | input | NUM_PADS | Pad routed to system control path, blocks wake |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register byte address |
| reg_wdata_i | input | REG_W | Write data |
| reg_rdata_o | output | REG_W | Read data for reg_addr_i, combinational |
| irq_o | output | 1 | Aggregated interrupt |
| wake_o | output | 1 | Aggregated wake request |

## Verification
A write-one clear and a freshly detected event can land on the same status bit at the same edge. The bench provokes this in two ways. It raises an edge-mode pad and times a clear so that the clear is active exactly at the edge where the event is detected. It also clears a bit whose level-mode input is still active. In both cases the bit must read back set afterwards. A behavioural model that applies clear-then-set on every edge also compares the read data and both output lines in every cycle.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;
  typedef enum logic [1:0] {
    EVT_LEVEL = 2'd0,
    EVT_EDGE  = 2'd1,
    EVT_OFF   = 2'd2,
    EVT_BOTH  = 2'd3
  } evt_mode_e;

  function automatic int unsigned ceil_div(int unsigned a, int unsigned b);
    return (a + b - 1) / b;
  endfunction

  // cur/old are already inverted when the invert bit is set
  function automatic logic pad_event(evt_mode_e m, logic cur, logic old);
    case (m)
      EVT_LEVEL: return cur;
      EVT_EDGE:  return cur & ~old;
      EVT_BOTH:  return cur ^ old;
      default:   return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect
  import gpio_evt_pkg::*;
#(
  parameter int NUM_PADS = 40,
  parameter int SLOTS    = 48
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_PADS-1:0]   pad_i,
  input  logic [2*NUM_PADS-1:0] evcfg_i,
  input  logic [NUM_PADS-1:0]   inv_i,
  output logic [SLOTS-1:0]      evt_o
);
  logic [NUM_PADS-1:0] sync_q1, sync_q2, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q1 <= '0;
      sync_q2 <= '0;
      prev_q  <= '0;
    end else begin
      sync_q1 <= pad_i;
      sync_q2 <= sync_q1;
      prev_q  <= sync_q2;
    end
  end

  for (genvar p = 0; p < SLOTS; p++) begin : g_slot
    if (p < NUM_PADS) begin : g_pad
      logic cur, old;
      assign cur = sync_q2[p] ^ inv_i[p];
      assign old = prev_q[p] ^ inv_i[p];
      assign evt_o[p] = pad_event(evt_mode_e'(evcfg_i[2*p +: 2]), cur, old);
    end else begin : g_spare
      assign evt_o[p] = 1'b0;
    end
  end
endmodule

// File: rtl/gpio_evt_stsbank.sv
module gpio_evt_stsbank #(
  parameter int WIDTH = 48
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] set_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] sts_o
);
  logic [WIDTH-1:0] sts_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sts_q <= '0;
    else         sts_q <= (sts_q & ~clr_i) | set_i;
  end

  assign sts_o = sts_q;

  // R7: an event in the same cycle as a clear still lands
  a_r7_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((sts_o & $past(set_i)) == $past(set_i)));

  // R6: cleared bits without a concurrent event read 0 next cycle
  a_r6_w1c_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(clr_i & ~set_i)) |=> ((sts_o & $past(clr_i & ~set_i)) == '0));
endmodule

// File: rtl/gpio_pad_evt_ctrl.sv
module gpio_pad_evt_ctrl
  import gpio_evt_pkg::*;
#(
  parameter int NUM_PADS   = 40,
  parameter int GROUP_SIZE = 24,
  parameter int ADDR_W     = 12,
  parameter int REG_W      = 32,
  parameter int STS_BASE   = 'h100,
  parameter int EN_BASE    = 'h120,
  parameter int WSTS_BASE  = 'h140,
  parameter int WEN_BASE   = 'h160
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_PADS-1:0]   pad_i,
  input  logic [2*NUM_PADS-1:0] evcfg_i,
  input  logic [NUM_PADS-1:0]   inv_i,
  input  logic [NUM_PADS-1:0]   sci_route_i,
  input  logic                  reg_wr_i,
  input  logic [ADDR_W-1:0]     reg_addr_i,
  input  logic [REG_W-1:0]      reg_wdata_i,
  output logic [REG_W-1:0]      reg_rdata_o,
  output logic                  irq_o,
  output logic                  wake_o
);
  localparam int NUM_GROUPS = ceil_div(NUM_PADS, GROUP_SIZE);
  localparam int SLOTS      = NUM_GROUPS * GROUP_SIZE;
  localparam logic [SLOTS-1:0] PAD_MASK = SLOTS'({NUM_PADS{1'b1}});

  logic [SLOTS-1:0] evt, int_sts, wk_sts, int_clr, wk_clr;
  logic [SLOTS-1:0] int_en_q, wk_en_q, sci_ext;
  logic             unused_wdata;

  assign unused_wdata = ^reg_wdata_i[REG_W-1:GROUP_SIZE];
  assign sci_ext      = SLOTS'(sci_route_i);

  gpio_evt_detect #(.NUM_PADS(NUM_PADS), .SLOTS(SLOTS)) u_det (
    .clk_i, .rst_ni, .pad_i, .evcfg_i, .inv_i, .evt_o(evt)
  );

  gpio_evt_stsbank #(.WIDTH(SLOTS)) u_int_sts (
    .clk_i, .rst_ni, .set_i(evt), .clr_i(int_clr), .sts_o(int_sts)
  );

  gpio_evt_stsbank #(.WIDTH(SLOTS)) u_wake_sts (
    .clk_i, .rst_ni, .set_i(evt), .clr_i(wk_clr), .sts_o(wk_sts)
  );

  always_comb begin
    int_clr = '0;
    wk_clr  = '0;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      if (reg_wr_i && reg_addr_i == ADDR_W'(STS_BASE + 4*g))
        int_clr[g*GROUP_SIZE +: GROUP_SIZE] = reg_wdata_i[GROUP_SIZE-1:0];
      if (reg_wr_i && reg_addr_i == ADDR_W'(WSTS_BASE + 4*g))
        wk_clr[g*GROUP_SIZE +: GROUP_SIZE] = reg_wdata_i[GROUP_SIZE-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      int_en_q <= '0;
      wk_en_q  <= '0;
    end else begin
      for (int g = 0; g < NUM_GROUPS; g++) begin
        if (reg_wr_i && reg_addr_i == ADDR_W'(EN_BASE + 4*g))
          int_en_q[g*GROUP_SIZE +: GROUP_SIZE] <= reg_wdata_i[GROUP_SIZE-1:0];
        if (reg_wr_i && reg_addr_i == ADDR_W'(WEN_BASE + 4*g))
          wk_en_q[g*GROUP_SIZE +: GROUP_SIZE] <= reg_wdata_i[GROUP_SIZE-1:0];
      end
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      if (reg_addr_i == ADDR_W'(STS_BASE + 4*g))
        reg_rdata_o = REG_W'(int_sts[g*GROUP_SIZE +: GROUP_SIZE]);
      if (reg_addr_i == ADDR_W'(EN_BASE + 4*g))
        reg_rdata_o = REG_W'(int_en_q[g*GROUP_SIZE +: GROUP_SIZE]);
      if (reg_addr_i == ADDR_W'(WSTS_BASE + 4*g))
        reg_rdata_o = REG_W'(wk_sts[g*GROUP_SIZE +: GROUP_SIZE]);
      if (reg_addr_i == ADDR_W'(WEN_BASE + 4*g))
        reg_rdata_o = REG_W'(wk_en_q[g*GROUP_SIZE +: GROUP_SIZE]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o  <= 1'b0;
      wake_o <= 1'b0;
    end else begin
      irq_o  <= |(int_sts & int_en_q);
      wake_o <= |(wk_sts & wk_en_q & ~sci_ext);
    end
  end

  // R8: interrupt only follows an enabled pending bit
  a_r8_irq_from_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(|(int_sts & int_en_q)));

  // R9: wake only follows an enabled, unrouted wake bit
  a_r9_wake_from_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> $past(|(wk_sts & wk_en_q & ~sci_ext)));

  // R10: spare slots of the last group stay quiet
  a_r10_spare_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((int_sts | wk_sts) & ~PAD_MASK) == '0);
endmodule

// File: tb/gpio_pad_evt_ctrl_bench.sv
module gpio_pad_evt_ctrl_bench;
  localparam int NP = 40;
  localparam int GS = 24;
  localparam int SL = 48;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [NP-1:0]   pad, inv, sci;
  logic [2*NP-1:0] cfg;
  logic            wr;
  logic [11:0]     addr;
  logic [31:0]     wdata;
  logic [31:0]     rdata;
  logic            irq, wake;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  gpio_pad_evt_ctrl u_gpio_pad_evt_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .pad_i(pad), .evcfg_i(cfg), .inv_i(inv),
    .sci_route_i(sci), .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq), .wake_o(wake)
  );

  // behavioural reference
  bit [SL-1:0] m_sts, m_en, m_wsts, m_wen;
  bit          m_irq, m_wake;
  bit [NP-1:0] h1, h2, h3;

  function automatic bit [SL-1:0] m_events();
    bit [SL-1:0] e = '0;
    for (int p = 0; p < NP; p++) begin
      bit now_v = h2[p] ^ inv[p];
      bit was_v = h3[p] ^ inv[p];
      case (cfg[2*p +: 2])
        2'd0: e[p] = now_v;
        2'd1: e[p] = now_v && !was_v;
        2'd3: e[p] = now_v != was_v;
        default: e[p] = 1'b0;
      endcase
    end
    return e;
  endfunction

  function automatic bit [SL-1:0] m_wmask(int base);
    bit [SL-1:0] m = '0;
    for (int g = 0; g < 2; g++)
      if (wr && addr == 12'(base + 4*g)) m[g*GS +: GS] = wdata[GS-1:0];
    return m;
  endfunction

  function automatic logic [31:0] m_read(logic [11:0] a);
    for (int g = 0; g < 2; g++) begin
      if (a == 12'(256 + 4*g)) return {8'h0, m_sts[g*GS +: GS]};
      if (a == 12'(288 + 4*g)) return {8'h0, m_en[g*GS +: GS]};
      if (a == 12'(320 + 4*g)) return {8'h0, m_wsts[g*GS +: GS]};
      if (a == 12'(352 + 4*g)) return {8'h0, m_wen[g*GS +: GS]};
    end
    return 32'h0;
  endfunction

  function automatic string tag_of(logic [11:0] a);
    if (a == 12'h100 || a == 12'h104) return "R6";
    if (a == 12'h120 || a == 12'h124) return "R8";
    if (a >= 12'h140 && a <= 12'h164) return "R9";
    return "R10";
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sts = '0; m_en = '0; m_wsts = '0; m_wen = '0;
      m_irq = 0; m_wake = 0; h1 = '0; h2 = '0; h3 = '0;
    end else begin
      bit [SL-1:0] e, c, wc;
      e  = m_events();
      c  = m_wmask('h100);
      wc = m_wmask('h140);
      m_irq  = |(m_sts & m_en);
      m_wake = |(m_wsts & m_wen & ~{8'h0, sci});
      m_sts  = (m_sts & ~c) | e;
      m_wsts = (m_wsts & ~wc) | e;
      for (int g = 0; g < 2; g++) begin
        if (wr && addr == 12'(288 + 4*g)) m_en[g*GS +: GS] = wdata[GS-1:0];
        if (wr && addr == 12'(352 + 4*g)) m_wen[g*GS +: GS] = wdata[GS-1:0];
      end
      h3 = h2; h2 = h1; h1 = pad;
    end
  end

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      #2;
      check(rdata == m_read(addr), tag_of(addr), rdata, m_read(addr));
      check(irq == m_irq, "R8", 32'(irq), 32'(m_irq));
      check(wake == m_wake, "R9", 32'(wake), 32'(m_wake));
    end
  end

  task automatic chk_rd(logic [11:0] a, logic [31:0] mask, logic [31:0] exp, string tag);
    @(negedge clk);
    addr = a;
    #1;
    check((rdata & mask) == exp, tag, rdata & mask, exp);
  endtask

  task automatic chk_out(bit sel_wake, bit exp, string tag);
    @(negedge clk);
    #1;
    if (sel_wake) check(wake == exp, tag, 32'(wake), 32'(exp));
    else          check(irq == exp, tag, 32'(irq), 32'(exp));
  endtask

  task automatic wr_reg(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    #(20 * 5000);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: actual hung expected completion");
      finish_run();
    end
  end

  initial begin
    pad = '0; inv = '0; sci = '0; cfg = {NP{2'b10}};
    wr = 1'b0; addr = 12'h100; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk_rd(12'h100, 32'hffffffff, 0, "R1");
    chk_rd(12'h104, 32'hffffffff, 0, "R1");
    chk_rd(12'h120, 32'hffffffff, 0, "R1");
    chk_rd(12'h124, 32'hffffffff, 0, "R1");
    chk_rd(12'h140, 32'hffffffff, 0, "R1");
    chk_rd(12'h144, 32'hffffffff, 0, "R1");
    chk_rd(12'h160, 32'hffffffff, 0, "R1");
    chk_rd(12'h164, 32'hffffffff, 0, "R1");
    chk_out(0, 0, "R1");
    chk_out(1, 0, "R1");

    @(negedge clk);
    cfg[1:0] = 2'd0;                  // pad0 level
    cfg[3:2] = 2'd1;                  // pad1 rising
    cfg[5:4] = 2'd1; inv[2] = 1'b1;   // pad2 falling
    cfg[7:6] = 2'd2;                  // pad3 off
    cfg[9:8] = 2'd3;                  // pad4 both
    cfg[11:10] = 2'd0; inv[5] = 1'b1; // pad5 active-low level
    cfg[61:60] = 2'd1;                // pad30 rising
    cfg[71:70] = 2'd3;                // pad35 both
    repeat (5) @(negedge clk);

    chk_rd(12'h100, 32'h20, 32'h20, "R2");
    chk_rd(12'h100, 32'h1f, 32'h00, "R2");
    wr_reg(12'h100, 32'h00ffffff);
    chk_rd(12'h100, 32'h20, 32'h20, "R2");

    @(negedge clk);
    pad[4:0] = 5'h1f; pad[30] = 1'b1; pad[35] = 1'b1;
    repeat (5) @(negedge clk);
    chk_rd(12'h100, 32'h01, 32'h01, "R2");
    chk_rd(12'h100, 32'h02, 32'h02, "R3");
    chk_rd(12'h100, 32'h04, 32'h00, "R3");
    chk_rd(12'h100, 32'h08, 32'h00, "R4");
    chk_rd(12'h100, 32'h10, 32'h10, "R5");
    chk_rd(12'h104, 32'h40, 32'h40, "R3");
    chk_rd(12'h104, 32'h800, 32'h800, "R5");

    wr_reg(12'h100, 32'h00ffffff);
    wr_reg(12'h104, 32'h00ffffff);
    repeat (2) @(negedge clk);
    chk_rd(12'h100, 32'h1f, 32'h01, "R2");
    chk_rd(12'h104, 32'hffffffff, 32'h0, "R6");

    @(negedge clk);
    pad[4:0] = 5'h00; pad[30] = 1'b0; pad[35] = 1'b0;
    repeat (5) @(negedge clk);
    chk_rd(12'h100, 32'h04, 32'h04, "R3");
    chk_rd(12'h100, 32'h10, 32'h10, "R5");
    chk_rd(12'h100, 32'h02, 32'h00, "R3");
    chk_rd(12'h100, 32'h08, 32'h00, "R4");
    chk_rd(12'h104, 32'h800, 32'h800, "R5");
    chk_rd(12'h104, 32'h40, 32'h00, "R3");

    wr_reg(12'h100, 32'h0);
    chk_rd(12'h100, 32'h10, 32'h10, "R6");
    wr_reg(12'h100, 32'h10);
    chk_rd(12'h100, 32'h14, 32'h04, "R6");

    // R8 interrupt aggregation
    chk_out(0, 0, "R8");
    wr_reg(12'h120, 32'h04);
    chk_out(0, 1, "R8");
    chk_rd(12'h120, 32'hffffffff, 32'h04, "R8");
    wr_reg(12'h100, 32'h04);
    chk_out(0, 0, "R8");

    // R9 wake path, kept apart from interrupt clears
    chk_rd(12'h140, 32'h14, 32'h14, "R9");
    @(negedge clk);
    sci[2] = 1'b1;
    wr_reg(12'h160, 32'h04);
    repeat (2) @(negedge clk);
    chk_out(1, 0, "R9");
    @(negedge clk);
    sci[2] = 1'b0;
    repeat (2) @(negedge clk);
    chk_out(1, 1, "R9");
    wr_reg(12'h140, 32'h04);
    chk_out(1, 0, "R9");
    chk_rd(12'h140, 32'h04, 32'h00, "R9");

    // R7 clear at the very edge the event is detected
    @(negedge clk);
    pad[1] = 1'b1;
    @(negedge clk);
    wr_reg(12'h100, 32'h02);
    chk_rd(12'h100, 32'h02, 32'h02, "R7");

    // R10 spare slots and unmapped addresses
    wr_reg(12'h124, 32'hffffffff);
    chk_rd(12'h124, 32'hffffffff, 32'h00ffffff, "R10");
    @(negedge clk);
    cfg = {NP{2'b11}};
    pad = '1;
    repeat (5) @(negedge clk);
    chk_rd(12'h104, 32'hffff0000, 32'h0, "R10");
    chk_rd(12'h144, 32'hffff0000, 32'h0, "R10");
    chk_rd(12'h104, 32'h0000ffff, 32'h0000ffff, "R10");
    chk_rd(12'h108, 32'hffffffff, 32'h0, "R10");
    chk_rd(12'h180, 32'hffffffff, 32'h0, "R10");
    chk_out(0, 1, "R8");

    repeat (2) @(negedge clk);
    done = 1'b1;
    finish_run();
  end
endmodule